// File: doc/BRIEF.md
# 16-bit Two-Stage RISC Core

A small 16-bit processor core with separate instruction and data memories. The core fetches one instruction word per cycle from a synchronous instruction ROM. It executes that word in the next cycle against a sixteen-entry register file of 16-bit registers. The data memory is reached through an address, a read strobe with its own return bus, and a write strobe with its own outgoing bus. Any memory-mapped peripheral sits on the same data port. Every data access completes within the cycle that issues it, and there is no stall input.

Each cycle the execute stage computes a candidate result for all sixteen opcodes side by side. The opcode then picks the one written to the destination register.

Branches do not flush the pipeline. The word already fetched behind a branch, call, return or loop instruction always runs (one delay slot), so one instruction completes every cycle after the first. The only conditional control transfer is a loop instruction that tests a register, decrements it, and branches while the tested value was nonzero.

Top module: `rc16_core`

## Requirements
- R1: While `rst` is high, `imem_addr` is 0 and neither data strobe is asserted. In the first cycle after `rst` falls, nothing executes, so both strobes stay low.
- R2: Without a control transfer, `imem_addr` advances by one every cycle. The word at address 0 executes in the cycle after the first clock edge following reset.
- R3: The instruction word holds the opcode in bits 15:12, the destination register in 11:8, the source register in 7:4 and a count field in 3:0. The opcodes are 0 rotate-right, 1 rotate-left, 2 add, 3 subtract, 4 xor, 5 and, 6 or, 7 not, 8 load, 9 store, A immediate, B multiply, C branch, D call, E return, F loop.
- R4: The immediate opcode writes bits 7:0, sign-extended to 16 bits, into the destination register.
- R5: Rotate-right and rotate-left write the source register, rotated by the count field, into the destination. A count of 0 copies the source unchanged.
- R6: Add and subtract combine the destination with the count field when that field is nonzero (1 to 15), and with the source register when it is 0. The result goes back to the destination, modulo 2^16.
- R7: Xor, and, and or combine the destination with the source register. Not writes the inverted destination.
- R8: Multiply forms the unsigned 32-bit product of destination and source, rotates it right by the count field, and writes the low 16 bits to the destination.
- R9: Load drives the source register on `dmem_addr`, asserts `dmem_rd`, and writes `dmem_rdata` to the destination. Store drives the source register on `dmem_addr` and the destination register on `dmem_wdata`, and asserts `dmem_wr`. The two strobes are never high together.
- R10: Branch (C) sets the next fetch address to the branch's own address plus bits 7:0 sign-extended. The word after the branch still executes, and the words between it and the target do not.
- R11: Call (D) branches like R10 and writes its own address plus 2 into the destination register. Return (E) fetches next from the address held in the destination register. Each has one delay slot.
- R12: Loop (F) writes the destination minus 1 back to the destination, wrapping from 0 to 0xFFFF. It branches like R10 only when the destination was nonzero before the decrement, and its delay slot always executes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Fetch address, registered |
| imem_rdata | input | 16 | Instruction word, one cycle after its address |
| dmem_addr | output | 16 | Data address, taken from the source register |
| dmem_rd | output | 1 | Load strobe |
| dmem_rdata | input | 16 | Load data, valid in the same cycle as `dmem_rd` |
| dmem_wr | output | 1 | Store strobe |
| dmem_wdata | output | 16 | Store data, taken from the destination register |

## Verification
The bench builds the core with its default parameters: a 16-bit data path and a 16-bit program counter. With these values the sign extension of 8-bit constants and branch offsets shows in full 16-bit results, and the loop counter's wrap from 0 to 0xFFFF becomes visible. Product bits above bit 15 moving down into the written result also become observable. Results leave the core only through store instructions, so each directed program ends by storing its registers to a behavioural data memory, whose contents the bench then compares with hand-computed values. Store and load strobe counts show which paths were skipped and how many times loop bodies and delay slots ran.

// File: rtl/rc16_pkg.sv
package rc16_pkg;
  localparam int INSTR_W = 16;
  localparam int RIDX_W  = 4;
  localparam int NREGS   = 1 << RIDX_W;

  typedef enum logic [3:0] {
    OP_ROR = 4'h0, OP_ROL = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
    OP_XOR = 4'h4, OP_AND = 4'h5, OP_OR  = 4'h6, OP_NOT = 4'h7,
    OP_LOD = 4'h8, OP_STO = 4'h9, OP_IMM = 4'hA, OP_MUL = 4'hB,
    OP_BRA = 4'hC, OP_BSR = 4'hD, OP_RET = 4'hE, OP_LOP = 4'hF
  } opcode_e;

  typedef struct packed {
    opcode_e           op;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs;
    logic [3:0]        cnt;
  } instr_t;
endpackage

// File: rtl/rc16_fetch.sv
module rc16_fetch #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] ex_pc,
  output logic            ex_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      ex_pc    <= '0;
      ex_valid <= 1'b0;
    end else begin
      pc_q     <= redirect ? target : pc_q + PC_W'(1);
      ex_pc    <= pc_q;
      ex_valid <= 1'b1;
    end
  end

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> (pc_q == '0));
  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> (pc_q == $past(pc_q) + PC_W'(1)));
  // R10
  pc_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (pc_q == $past(target)));
endmodule

// File: rtl/rc16_regfile.sv
module rc16_regfile
  import rc16_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [RIDX_W-1:0]   waddr,
  input  logic [XLEN-1:0]     wdata,
  input  logic [RIDX_W-1:0]   raddr_d,
  input  logic [RIDX_W-1:0]   raddr_s,
  output logic [XLEN-1:0]     rdata_d,
  output logic [XLEN-1:0]     rdata_s
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rdata_d = regs[raddr_d];
  assign rdata_s = regs[raddr_s];

  // R3
  rf_write_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/rc16_exec.sv
module rc16_exec
  import rc16_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int PC_W = 16
) (
  input  instr_t          ins,
  input  logic [XLEN-1:0] dval,
  input  logic [XLEN-1:0] sval,
  input  logic [XLEN-1:0] ld_data,
  input  logic [PC_W-1:0] ex_pc,
  output logic            wb_en,
  output logic [XLEN-1:0] wb_val,
  output logic            redirect,
  output logic [PC_W-1:0] target
);
  localparam int DW = 2 * XLEN;

  logic [7:0]      imm8;
  logic [XLEN-1:0] simm;
  logic [PC_W-1:0] boff;
  logic [XLEN-1:0] addend;
  logic [DW-1:0]   twice;
  logic [DW-1:0]   prod;
  logic [XLEN-1:0] res [16];

  always_comb begin
    imm8   = {ins.rs, ins.cnt};
    simm   = {{(XLEN-8){imm8[7]}}, imm8};
    boff   = {{(PC_W-8){imm8[7]}}, imm8};
    addend = (ins.cnt != 4'd0) ? XLEN'(ins.cnt) : sval;
    twice  = {sval, sval};
    prod   = DW'(dval) * DW'(sval);

    res[OP_ROR] = XLEN'(twice >> ins.cnt);
    res[OP_ROL] = XLEN'((twice << ins.cnt) >> XLEN);
    res[OP_ADD] = dval + addend;
    res[OP_SUB] = dval - addend;
    res[OP_XOR] = dval ^ sval;
    res[OP_AND] = dval & sval;
    res[OP_OR]  = dval | sval;
    res[OP_NOT] = ~dval;
    res[OP_LOD] = ld_data;
    res[OP_STO] = dval;
    res[OP_IMM] = simm;
    res[OP_MUL] = XLEN'(prod >> ins.cnt);
    res[OP_BRA] = dval;
    res[OP_BSR] = XLEN'(ex_pc + PC_W'(2));
    res[OP_RET] = dval;
    res[OP_LOP] = dval - XLEN'(1);

    wb_val   = res[ins.op];
    wb_en    = !(ins.op inside {OP_STO, OP_BRA, OP_RET});
    redirect = (ins.op inside {OP_BRA, OP_BSR, OP_RET}) ||
               ((ins.op == OP_LOP) && (dval != '0));
    target   = (ins.op == OP_RET) ? PC_W'(dval) : ex_pc + boff;
  end
endmodule

// File: rtl/rc16_core.sv
module rc16_core
  import rc16_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] imem_addr,
  input  logic [15:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic            dmem_rd,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            dmem_wr,
  output logic [XLEN-1:0] dmem_wdata
);
  logic            redirect;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] ex_pc;
  logic            ex_valid;
  instr_t          ins;
  logic [XLEN-1:0] dval;
  logic [XLEN-1:0] sval;
  logic            wb_en;
  logic [XLEN-1:0] wb_val;

  rc16_fetch #(.PC_W(PC_W)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .redirect (redirect),
    .target   (target),
    .pc_q     (imem_addr),
    .ex_pc    (ex_pc),
    .ex_valid (ex_valid)
  );

  // An invalid slot executes as opcode 0 with count 0 on r0: a no-op.
  assign ins = ex_valid ? instr_t'(imem_rdata) : '0;

  rc16_regfile #(.XLEN(XLEN)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wb_en),
    .waddr   (ins.rd),
    .wdata   (wb_val),
    .raddr_d (ins.rd),
    .raddr_s (ins.rs),
    .rdata_d (dval),
    .rdata_s (sval)
  );

  rc16_exec #(.XLEN(XLEN), .PC_W(PC_W)) u_exec (
    .ins      (ins),
    .dval     (dval),
    .sval     (sval),
    .ld_data  (dmem_rdata),
    .ex_pc    (ex_pc),
    .wb_en    (wb_en),
    .wb_val   (wb_val),
    .redirect (redirect),
    .target   (target)
  );

  assign dmem_addr  = sval;
  assign dmem_wdata = dval;
  assign dmem_rd    = (ins.op == OP_LOD);
  assign dmem_wr    = (ins.op == OP_STO);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dmem_rd && dmem_wr));
  // R1
  no_exec_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dmem_rd && !dmem_wr));
endmodule

// File: tb/rc16_core_tb.sv
`timescale 1ns/1ps
module rc16_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr;
  logic [15:0] imem_rdata = '0;
  logic [15:0] dmem_addr;
  logic        dmem_rd;
  logic [15:0] dmem_rdata;
  logic        dmem_wr;
  logic [15:0] dmem_wdata;

  logic [15:0] rom [256];
  logic [15:0] ram [256];
  int checks = 0, fails = 0, wp = 0, wr_cnt = 0, rd_cnt = 0, wr_base = 0, rd_base = 0;

  always #2.5 clk = ~clk;

  rc16_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_rdata(dmem_rdata),
    .dmem_wr(dmem_wr), .dmem_wdata(dmem_wdata)
  );

  always @(posedge clk) imem_rdata <= rom[imem_addr[7:0]];
  assign dmem_rdata = ram[dmem_addr[7:0]];
  always @(posedge clk) begin
    if (dmem_wr) begin ram[dmem_addr[7:0]] <= dmem_wdata; wr_cnt <= wr_cnt + 1; end
    if (dmem_rd) rd_cnt <= rd_cnt + 1;
  end

  function automatic logic [15:0] ins(input logic [3:0] op, d, s, c);
    return {op, d, s, c};
  endfunction
  function automatic logic [15:0] ins8(input logic [3:0] op, d, input logic [7:0] v);
    return {op, d, v};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic emit(input logic [15:0] w);
    rom[wp] = w;
    wp++;
  endtask

  task automatic prep(input logic [15:0] fill);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin rom[i] = fill; ram[i] = '0; end
    wp = 0;
  endtask

  task automatic run(input int n);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wr_base = wr_cnt;
    rd_base = rd_cnt;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    prep(ins(4'h9, 4'h0, 4'h0, 4'h0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc in reset", imem_addr, 16'h0000);
    chk("R1 wr in reset", {15'b0, dmem_wr}, 16'h0);
    chk("R1 rd in reset", {15'b0, dmem_rd}, 16'h0);
    rst = 1'b0;
    #1;
    chk("R1 first cycle idle", {15'b0, dmem_wr}, 16'h0);
    @(negedge clk);
    chk("R2 fetch addr 1", imem_addr, 16'h0001);
    chk("R9 store strobe", {15'b0, dmem_wr}, 16'h1);
    @(negedge clk);
    chk("R2 fetch addr 2", imem_addr, 16'h0002);
    @(negedge clk);
    chk("R2 fetch addr 3", imem_addr, 16'h0003);
  endtask

  task automatic t_alu;
    logic [15:0] bump;
    bump = ins(4'h2, 4'hF, 4'h0, 4'h1);
    prep(16'h0000);
    ram[8'h2A] = 16'hBEEF;
    emit(ins8(4'hA, 4'hF, 8'h20));
    emit(ins8(4'hA, 4'h1, 8'h12));
    emit(ins8(4'hA, 4'h2, 8'hFD));
    emit(ins8(4'hA, 4'h3, 8'h81));
    emit(ins(4'h0, 4'h4, 4'h1, 4'h0));
    emit(ins(4'h2, 4'h4, 4'h2, 4'h0));
    emit(ins(4'h9, 4'h4, 4'hF, 4'h0)); emit(bump);
    emit(ins(4'h0, 4'h5, 4'h1, 4'h4));
    emit(ins(4'h9, 4'h5, 4'hF, 4'h0)); emit(bump);
    emit(ins(4'h1, 4'h6, 4'h3, 4'h8));
    emit(ins(4'h9, 4'h6, 4'hF, 4'h0)); emit(bump);
    emit(ins(4'h3, 4'h1, 4'h0, 4'h5));
    emit(ins(4'h9, 4'h1, 4'hF, 4'h0)); emit(bump);
    emit(ins(4'h3, 4'h2, 4'h1, 4'h0));
    emit(ins(4'h9, 4'h2, 4'hF, 4'h0)); emit(bump);
    emit(ins(4'h4, 4'h3, 4'h2, 4'h0));
    emit(ins(4'h9, 4'h3, 4'hF, 4'h0)); emit(bump);
    emit(ins(4'h5, 4'h2, 4'h5, 4'h0));
    emit(ins(4'h9, 4'h2, 4'hF, 4'h0)); emit(bump);
    emit(ins(4'h6, 4'h3, 4'h1, 4'h0));
    emit(ins(4'h9, 4'h3, 4'hF, 4'h0)); emit(bump);
    emit(ins(4'h7, 4'h5, 4'h0, 4'h0));
    emit(ins(4'h9, 4'h5, 4'hF, 4'h0)); emit(bump);
    emit(ins8(4'hA, 4'h7, 8'h81));
    emit(ins8(4'hA, 4'h8, 8'h02));
    emit(ins(4'hB, 4'h7, 4'h8, 4'h4));
    emit(ins(4'h9, 4'h7, 4'hF, 4'h0)); emit(bump);
    emit(ins(4'h8, 4'hB, 4'hF, 4'h0)); emit(bump);
    emit(ins(4'h9, 4'hB, 4'hF, 4'h0)); emit(bump);
    emit(ins8(4'hA, 4'h9, 8'hFF));
    emit(ins(4'h2, 4'h9, 4'h0, 4'hF));
    emit(ins(4'h9, 4'h9, 4'hF, 4'h0));
    run(wp + 8);
    chk("R5 R6 move then add reg", ram[8'h20], 16'h000F);
    chk("R5 rotate right 4", ram[8'h21], 16'h2001);
    chk("R5 R4 rotate left 8 of sext", ram[8'h22], 16'hFF81 == 16'hFF81 ? 16'h81FF : 16'h0);
    chk("R6 sub quick 5", ram[8'h23], 16'h000D);
    chk("R6 sub reg", ram[8'h24], 16'hFFF0);
    chk("R7 xor", ram[8'h25], 16'h0071);
    chk("R7 and", ram[8'h26], 16'h2000);
    chk("R7 or", ram[8'h27], 16'h007D);
    chk("R7 not", ram[8'h28], 16'hDFFE);
    chk("R8 multiply shift 4", ram[8'h29], 16'h1FF0);
    chk("R9 load then store", ram[8'h2B], 16'hBEEF);
    chk("R4 R6 sext ff plus 15", ram[8'h2C], 16'h000E);
    chk("R9 store count", 16'(wr_cnt - wr_base), 16'd12);
    chk("R9 load count", 16'(rd_cnt - rd_base), 16'd1);
  endtask

  task automatic t_branch;
    prep(16'h0000);
    emit(ins8(4'hA, 4'hF, 8'h40));
    emit(ins8(4'hA, 4'h1, 8'h01));
    emit(ins8(4'hC, 4'h0, 8'h04));
    emit(ins8(4'hA, 4'h1, 8'h02));
    emit(ins8(4'hA, 4'h1, 8'h03));
    emit(ins8(4'hA, 4'h1, 8'h04));
    emit(ins(4'h9, 4'h1, 4'hF, 4'h0));
    emit(ins(4'h2, 4'hF, 4'h0, 4'h1));
    emit(ins8(4'hD, 4'hC, 8'h05));
    emit(ins8(4'hA, 4'h2, 8'h55));
    emit(ins(4'h9, 4'h2, 4'hF, 4'h0));
    emit(ins8(4'hC, 4'h0, 8'h00));
    emit(16'h0000);
    emit(ins(4'h2, 4'hF, 4'h0, 4'h1));
    emit(ins(4'h9, 4'hC, 4'hF, 4'h0));
    emit(ins8(4'hE, 4'hC, 8'h00));
    emit(ins(4'h3, 4'hF, 4'h0, 4'h1));
    run(40);
    chk("R10 delay slot ran, path skipped", ram[8'h40], 16'h0002);
    chk("R11 link is call plus 2", ram[8'h42], 16'h000A);
    chk("R11 return and delay slot", ram[8'h41], 16'h0055);
    chk("R10 self loop stores once each", 16'(wr_cnt - wr_base), 16'd3);
  endtask

  task automatic t_loop;
    prep(16'h0000);
    emit(ins8(4'hA, 4'hF, 8'h60));
    emit(ins8(4'hA, 4'h1, 8'h03));
    emit(ins8(4'hA, 4'h2, 8'h00));
    emit(ins8(4'hA, 4'h4, 8'h00));
    emit(ins(4'h2, 4'h2, 4'h0, 4'h1));
    emit(ins8(4'hF, 4'h1, 8'hFF));
    emit(ins(4'h2, 4'h4, 4'h0, 4'h2));
    emit(ins(4'h9, 4'h2, 4'hF, 4'h0));
    emit(ins(4'h2, 4'hF, 4'h0, 4'h1));
    emit(ins(4'h9, 4'h4, 4'hF, 4'h0));
    emit(ins(4'h2, 4'hF, 4'h0, 4'h1));
    emit(ins(4'h9, 4'h1, 4'hF, 4'h0));
    run(wp + 20);
    chk("R12 body runs count+1", ram[8'h60], 16'h0004);
    chk("R12 delay slot every pass", ram[8'h61], 16'h0008);
    chk("R12 counter wraps", ram[8'h62], 16'hFFFF);
    chk("R12 store count", 16'(wr_cnt - wr_base), 16'd3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_branch();
    t_loop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule